// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block keeps one captured 64-bit time value for received precision-time packets and one for transmitted ones. A packet classifier outside the block decides which packets qualify and raises a one-cycle event strobe with the packet's 16-bit sequence identifier. On that strobe the block copies the free-running time counter and the identifier into the slot for that direction.

Each slot holds a single entry and does not overwrite itself. Once its valid flag is set, the slot keeps its contents until software clears the flag. Any event that arrives in the meantime is discarded, and a sticky overflow bit records the loss. Software works through a small register port with an address, a write strobe and write data, plus a read-data bus that follows the address combinationally. Through this port it enables each direction, reads the status word and the two halves of the time value, and acknowledges a slot with write-one-to-clear.

Top module: `ts_capture_latch`

## Requirements
- R1: After reset, every register reads zero. This covers the control word at address 0 and the status words at addresses 1 (receive) and 4 (transmit), so both directions start disabled, empty and without overflow.
- R2: When a direction is enabled and its valid flag is 0, an event strobe sets the flag. The status word then reads {overflow at bit 17, valid at bit 16, identifier in bits 15:0}. The slot's low word (address 2 receive, 5 transmit) and high word (address 3 receive, 6 transmit) return the time value present in the strobe cycle.
- R3: While the valid flag is 1, further events change neither the stored time value nor the identifier.
- R4: Writing a status word with bit 16 set clears that slot's valid flag. A write with bit 16 at 0 leaves the flag unchanged. After the clear, the next event is captured again.
- R5: An enabled event that finds the valid flag set raises the overflow bit (bit 17). The bit stays set until a status write with bit 17 set clears it.
- R6: Control bit 0 enables the receive direction and bit 1 enables the transmit direction. While a direction is disabled, its events are ignored: no capture and no overflow.
- R7: A control write that turns a direction's enable from 0 to 1 clears that slot's valid and overflow bits. Rewriting an enable that is already 1 clears nothing.
- R8: A pulse on the receive-filter reload input clears the receive valid flag and leaves the transmit slot untouched.
- R9: The receive and transmit slots are independent. A capture, clear or overflow in one never changes the other.
- R10: Reading any register has no side effects. After the valid flag is cleared, the time words still return the last captured value.
- R11: An event in the same cycle as a valid-clearing status write is discarded and counted as overflow. The flag ends at 0 and the stored value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | TS_W | Free-running time counter |
| rx_evt | input | 1 | Qualified receive packet strobe |
| rx_seq | input | SEQ_W | Receive packet sequence identifier |
| tx_evt | input | 1 | Qualified transmit packet strobe |
| tx_seq | input | SEQ_W | Transmit packet sequence identifier |
| rx_rule_load | input | 1 | Pulse when the receive filters are reprogrammed |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for reg_addr |

## Verification
The assertions assume that each event strobe is a one-cycle pulse sampled on the clock edge. They assume `time_now` and the identifiers are steady at that edge, and that the control and status registers are written only at their fixed addresses. The stimulus changes every input on the falling edge and holds each strobe for exactly one cycle. It reads registers only while no write is pending, so a read never overlaps a write to the same slot. The one intended overlap is the single cycle that pairs an event with a clearing write.

// File: rtl/ts_capture_latch.sv
module ts_capture_latch #(
  parameter int TS_W    = 64,
  parameter int DW      = 32,
  parameter int SEQ_W   = 16,
  parameter int AW      = 4,
  parameter int VLD_BIT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TS_W-1:0]  time_now,
  input  logic             rx_evt,
  input  logic [SEQ_W-1:0] rx_seq,
  input  logic             tx_evt,
  input  logic [SEQ_W-1:0] tx_seq,
  input  logic             rx_rule_load,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata
);
  localparam int NP = 2;
  localparam int OVF_BIT = VLD_BIT + 1;
  localparam logic [AW-1:0] A_CTRL = '0;

  logic [NP-1:0]            en_q, vld_q, ovf_q;
  logic [NP-1:0][TS_W-1:0]  ts_q;
  logic [NP-1:0][SEQ_W-1:0] seq_q;

  wire [NP-1:0]            evt    = {tx_evt, rx_evt};
  wire [NP-1:0][SEQ_W-1:0] seq_in = {tx_seq, rx_seq};
  wire                     ctrl_wr = reg_wr && reg_addr == A_CTRL;

  always_ff @(posedge clk) begin
    if (!rst_n)       en_q <= '0;
    else if (ctrl_wr) en_q <= reg_wdata[NP-1:0];
  end

  for (genvar p = 0; p < NP; p++) begin : g_path
    localparam logic [AW-1:0] A_STAT = AW'(1 + 3 * p);
    logic             vld, ovf;
    logic [TS_W-1:0]  ts;
    logic [SEQ_W-1:0] seq;

    wire stat_wr = reg_wr && reg_addr == A_STAT;
    wire en_rise = ctrl_wr && reg_wdata[p] && !en_q[p];
    wire reload  = (p == 0) ? rx_rule_load : 1'b0;
    wire clr_v   = (stat_wr && reg_wdata[VLD_BIT]) || en_rise || reload;
    wire clr_o   = (stat_wr && reg_wdata[OVF_BIT]) || en_rise;
    wire take    = evt[p] && en_q[p] && !vld;
    wire drop    = evt[p] && en_q[p] && vld;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld <= 1'b0;
        ovf <= 1'b0;
        ts  <= '0;
        seq <= '0;
      end else begin
        if (take) begin
          ts  <= time_now;
          seq <= seq_in[p];
        end
        if (take)       vld <= 1'b1;
        else if (clr_v) vld <= 1'b0;
        if (drop)       ovf <= 1'b1;
        else if (clr_o) ovf <= 1'b0;
      end
    end

    assign vld_q[p] = vld;
    assign ovf_q[p] = ovf;
    assign ts_q[p]  = ts;
    assign seq_q[p] = seq;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL) reg_rdata[NP-1:0] = en_q;
    for (int p = 0; p < NP; p++) begin
      if (reg_addr == AW'(1 + 3 * p)) begin
        reg_rdata[SEQ_W-1:0] = seq_q[p];
        reg_rdata[VLD_BIT]   = vld_q[p];
        reg_rdata[OVF_BIT]   = ovf_q[p];
      end
      if (reg_addr == AW'(2 + 3 * p)) reg_rdata = ts_q[p][DW-1:0];
      if (reg_addr == AW'(3 + 3 * p)) reg_rdata = ts_q[p][TS_W-1:DW];
    end
  end
endmodule

// File: rtl/ts_capture_latch_chk.sv
module ts_capture_latch_chk #(
  parameter int TS_W  = 64,
  parameter int DW    = 32,
  parameter int SEQ_W = 16,
  parameter int AW    = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [TS_W-1:0]          time_now,
  input logic                     rx_evt,
  input logic                     tx_evt,
  input logic                     reg_wr,
  input logic [AW-1:0]            reg_addr,
  input logic [1:0]               en_q,
  input logic [1:0]               vld_q,
  input logic [1:0]               ovf_q,
  input logic [1:0][TS_W-1:0]     ts_q
);
  // R2
  rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt && en_q[0] && !vld_q[0] |=> vld_q[0] && ts_q[0] == $past(time_now));
  // R2
  tx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_evt && en_q[1] && !vld_q[1] |=> vld_q[1] && ts_q[1] == $past(time_now));
  // R3
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q[0] |=> $stable(ts_q[0]));
  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q[1] |=> $stable(ts_q[1]));
  // R6
  rx_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[0] && !vld_q[0] |=> !vld_q[0]);
  // R6
  tx_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[1] && !vld_q[1] |=> !vld_q[1]);
  // R5
  rx_ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt && en_q[0] && vld_q[0] |=> ovf_q[0]);
  // R5
  tx_ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_evt && en_q[1] && vld_q[1] |=> ovf_q[1]);
  // R5
  rx_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q[0] && !reg_wr |=> ovf_q[0]);
  // R5
  tx_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q[1] && !reg_wr |=> ovf_q[1]);
endmodule

bind ts_capture_latch ts_capture_latch_chk #(
  .TS_W(TS_W), .DW(DW), .SEQ_W(SEQ_W), .AW(AW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .time_now(time_now),
  .rx_evt(rx_evt), .tx_evt(tx_evt),
  .reg_wr(reg_wr), .reg_addr(reg_addr),
  .en_q(en_q), .vld_q(vld_q), .ovf_q(ovf_q), .ts_q(ts_q)
);

// File: tb/ts_capture_latch_tb_top.sv
module ts_capture_latch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] time_now = '0;
  logic        rx_evt = 1'b0, tx_evt = 1'b0, rx_rule_load = 1'b0;
  logic [15:0] rx_seq = '0, tx_seq = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [3:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];
  event  rd_ev;

  always #5 clk = ~clk;

  ts_capture_latch dut_i (
    .clk(clk), .rst_n(rst_n), .time_now(time_now),
    .rx_evt(rx_evt), .rx_seq(rx_seq), .tx_evt(tx_evt), .tx_seq(tx_seq),
    .rx_rule_load(rx_rule_load), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  initial begin
    forever begin
      @(rd_ev);
      #1;
      while (sb_q.size() != 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (reg_rdata !== it.exp) begin
          fails++;
          $display("FAIL %s addr %0d: got %h expected %h", it.tag, it.addr, reg_rdata, it.exp);
        end
      end
    end
  end

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    reg_addr = a;
    it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    -> rd_ev;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rx_pulse(input logic [63:0] t, input logic [15:0] s);
    rx_evt = 1'b1; rx_seq = s; time_now = t;
    @(negedge clk);
    rx_evt = 1'b0;
  endtask

  task automatic tx_pulse(input logic [63:0] t, input logic [15:0] s);
    tx_evt = 1'b1; tx_seq = s; time_now = t;
    @(negedge clk);
    tx_evt = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'd0, 32'h0, "R1 ctrl");
    rd(4'd1, 32'h0, "R1 rx status");
    rd(4'd4, 32'h0, "R1 tx status");

    wr(4'd0, 32'h3);
    rd(4'd0, 32'h3, "R6 ctrl enables");
    rx_pulse(64'h1122334455667788, 16'h00A5);
    rd(4'd1, 32'h000100A5, "R2 rx status");
    rd(4'd2, 32'h55667788, "R2 rx low");
    rd(4'd3, 32'h11223344, "R2 rx high");
    rd(4'd4, 32'h0, "R9 tx untouched");

    rx_pulse(64'h9999999999999999, 16'h0001);
    rd(4'd1, 32'h000300A5, "R3 R5 held and overflow");
    rd(4'd2, 32'h55667788, "R3 low held");

    wr(4'd1, 32'h0);
    rd(4'd1, 32'h000300A5, "R4 zero write no effect");
    wr(4'd1, 32'h00010000);
    rd(4'd1, 32'h000200A5, "R4 valid cleared");
    rd(4'd2, 32'h55667788, "R10 low after clear");
    rd(4'd2, 32'h55667788, "R10 repeat read");
    wr(4'd1, 32'h00020000);
    rd(4'd1, 32'h000000A5, "R5 overflow cleared");

    rx_pulse(64'hAAAA0000BBBB0001, 16'h0007);
    rd(4'd1, 32'h00010007, "R4 recapture");
    rd(4'd3, 32'hAAAA0000, "R4 recapture high");

    tx_pulse(64'hDEADBEEF01234567, 16'h1234);
    rd(4'd4, 32'h00011234, "R2 tx status");
    rd(4'd5, 32'h01234567, "R2 tx low");
    rd(4'd6, 32'hDEADBEEF, "R2 tx high");
    rd(4'd1, 32'h00010007, "R9 rx untouched");

    rx_rule_load = 1'b1;
    @(negedge clk);
    rx_rule_load = 1'b0;
    rd(4'd1, 32'h00000007, "R8 reload clears rx");
    rd(4'd4, 32'h00011234, "R8 tx untouched");

    wr(4'd0, 32'h3);
    rd(4'd4, 32'h00011234, "R7 no rise no clear");
    wr(4'd0, 32'h1);
    tx_pulse(64'h5, 16'h0BAD);
    rd(4'd4, 32'h00011234, "R6 tx disabled ignored");
    wr(4'd0, 32'h3);
    rd(4'd4, 32'h00001234, "R7 enable rise clears");

    wr(4'd0, 32'h2);
    rx_pulse(64'h6, 16'h0BAD);
    rd(4'd1, 32'h00000007, "R6 rx disabled ignored");
    wr(4'd0, 32'h3);
    rx_pulse(64'h0000000100000002, 16'h0009);
    rd(4'd1, 32'h00010009, "R11 setup capture");

    reg_wr = 1'b1; reg_addr = 4'd1; reg_wdata = 32'h00010000;
    rx_evt = 1'b1; rx_seq = 16'h000A; time_now = 64'h77;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; rx_evt = 1'b0;
    rd(4'd1, 32'h00020009, "R11 event with clear");
    rd(4'd2, 32'h00000002, "R11 value kept");

    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule